// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block reads a circular chain of transmit descriptors from system memory and builds frames from the buffer fragments they point to. Each descriptor is 16 bytes long and sits at a word-aligned address. It holds four 32-bit words, read in this order: a status word, a control word with the fragment size and a last-fragment marker, the address of the fragment buffer, and the address of the next descriptor. The fragments are copied into a local packet store. When the fragment marked last has been copied, the whole frame goes out on a byte stream.

Software sets the ownership bit in the status word of each descriptor it hands to the engine, then pulses `start` together with the address of the first descriptor. The engine returns ownership one descriptor at a time by writing the status word back. When the walk ends, `busy` drops, and `tx_done` rises if at least one frame was sent. If a frame would not fit in the local store, the engine marks a length error in the status word of the offending descriptor and ends the walk.

Top module: `txd_gather`

## Requirements
- R1: After reset, `busy`, `tx_done`, `mem_req_valid` and `frm_valid` are 0.
- R2: A descriptor at address D is fetched as four reads, in order, at D, D+4, D+8 and D+12: status, control, buffer address, next address.
- R3: A descriptor is used only when bit 31 of its status word is set. Starting at the head, the engine skips unowned descriptors by following their next pointers. It gives up without sending anything when the next pointer is zero or equals the head.
- R4: The fragment size is bits 10:0 of the control word. The engine reads ceil(size/4) words starting at the buffer address and takes the bytes of each word least significant byte first.
- R5: After a fragment is copied, the status word is written back to the descriptor address with bit 31 cleared and every other bit unchanged, with all four byte enables set.
- R6: When the fragment with control bit 30 set has been copied, the concatenated frame is sent one byte per cycle. `frm_sof` is set on the first byte and `frm_eof` on the last. A frame of zero bytes is not sent.
- R7: Once a descriptor has been used, the engine fetches the descriptor its next pointer names and stops at the first one that is not owned. It also stops if the next pointer is zero.
- R8: If the bytes already gathered plus the new fragment size would exceed the store size (2048), nothing from that fragment is copied. Its status is written back with bit 14 set and bit 31 still set, no frame is sent for the partial data, and the walk ends.
- R9: When a walk ends, `busy` falls. `tx_done` is set if at least one frame was sent in that walk. A new accepted `start` clears `tx_done`.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, data and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| head_ptr | input | 32 | Address of the first descriptor, sampled with `start` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word address in bytes |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte enables for writes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| frm_valid | output | 1 | Frame byte valid |
| frm_data | output | 8 | Frame byte |
| frm_sof | output | 1 | First byte of a frame |
| frm_eof | output | 1 | Last byte of a frame |
| busy | output | 1 | Walk in progress |
| tx_done | output | 1 | Sticky: the last walk sent at least one frame |

## Verification
The bench aims at fragment sizes that are not a multiple of four and at zero-size fragments. A design that packs bytes wrongly would shift or drop bytes at fragment seams. It fills the store to exactly 2048 bytes, then overflows it, so an off-by-one in the limit shows up as a spurious length error or a missing one. It checks that unowned heads are skipped and that a ring with no owned descriptor ends without sending anything, which catches a walk that never ends or one that sends stale data. It also checks that a second `start` during a walk neither restarts the walk nor changes its target.

// File: rtl/txd_pkg.sv
// Shared constants and state encoding for the transmit gather engine.
// Assumes 32-bit memory words and 16-byte descriptors.
package txd_pkg;
    localparam int unsigned CNT_W      = 11;  // fragment size field width
    localparam int unsigned OWN_BIT    = 31;  // status: descriptor owned by engine
    localparam int unsigned LENERR_BIT = 14;  // status: frame too long
    localparam int unsigned LAST_BIT   = 30;  // control: last fragment of frame

    typedef enum logic [3:0] {
        W_IDLE,
        W_DFETCH,
        W_CHECK,
        W_BFETCH,
        W_WBACK,
        W_EMIT,
        W_NEXT,
        W_DONE
    } walk_st_t;
endpackage

// File: rtl/txd_pktbuf.sv
// Byte-addressed packet store. Accepts up to four bytes per cycle at any
// byte offset (lower lane first) and gives one byte by asynchronous read.
// Assumes the writer never asks for bytes past the end of the store.
module txd_pktbuf #(
    parameter  int unsigned BYTES = 2048,
    localparam int unsigned IDX_W = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W:0]   wr_base,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       wr_nb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0]       store [BYTES];
    logic [3:0]       lane_en;
    logic [IDX_W-1:0] lane_idx [4];

    // Per-lane target address and enable
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [IDX_W:0] a;
        assign a           = wr_base + (IDX_W+1)'(g);
        assign lane_en[g]  = wr_en && (3'(g) < wr_nb) && (a < (IDX_W+1)'(BYTES));
        assign lane_idx[g] = a[IDX_W-1:0];
    end

    // Byte lane writes
    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (lane_en[i]) store[lane_idx[i]] <= wr_data[8*i +: 8];
        end
    end

    assign rd_data = store[rd_idx];

    p_write_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_base} + (IDX_W+2)'(wr_nb)) <= (IDX_W+2)'(BYTES));
endmodule

// File: rtl/txd_emit.sv
// Streams the first len bytes of the packet store, one per cycle, with
// start and end markers. Starts on go when idle; len must be non-zero.
module txd_emit #(
    parameter int unsigned LEN_W = 12,
    parameter int unsigned IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] rd_idx,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof
);
    logic             active;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] len_r;

    // Byte index sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            len_r  <= '0;
        end else if (go && !active) begin
            active <= 1'b1;
            idx    <= '0;
            len_r  <= len;
        end else if (active) begin
            if (idx == len_r - LEN_W'(1)) active <= 1'b0;
            else                          idx    <= idx + LEN_W'(1);
        end
    end

    assign rd_idx    = idx[IDX_W-1:0];
    assign out_valid = active;
    assign out_sof   = active && (idx == '0);
    assign out_eof   = active && (idx == len_r - LEN_W'(1));

    p_eof_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_valid);
    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> idx < len_r);
endmodule

// File: rtl/txd_gather.sv
// Walks a ring of transmit descriptors, gathers owned fragments into a
// local store, returns ownership per descriptor and streams each finished
// frame. Assumes word-aligned descriptor and buffer addresses, in-order
// read responses and one outstanding request at a time.
module txd_gather
    import txd_pkg::*;
#(
    parameter  int unsigned BUF_BYTES = 2048,
    localparam int unsigned IDX_W     = $clog2(BUF_BYTES),
    localparam int unsigned LEN_W     = IDX_W + 1,
    localparam int unsigned SUM_W     = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] head_ptr,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    output logic [3:0]  mem_req_be,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        frm_valid,
    output logic [7:0]  frm_data,
    output logic        frm_sof,
    output logic        frm_eof,
    output logic        busy,
    output logic        tx_done
);
    walk_st_t         st;
    logic [31:0]      head, cur;
    logic [31:0]      d_stat, d_buf, d_next;
    logic [CNT_W-1:0] d_cnt;
    logic             d_last;
    logic [1:0]       widx;
    logic             searching, sent, lenerr, em_go;
    logic [LEN_W-1:0] flen;
    logic [CNT_W-1:0] remain;
    logic [31:0]      baddr;
    logic [2:0]       nb;
    logic             overflow;
    logic             hs;
    logic [IDX_W-1:0] em_idx;

    assign hs       = mem_req_valid && mem_req_ready;
    assign nb       = (remain >= CNT_W'(4)) ? 3'd4 : remain[2:0];
    assign overflow = (SUM_W'(flen) + SUM_W'(d_cnt)) > SUM_W'(BUF_BYTES);
    assign mem_req_be = {4{mem_req_write}};

    // Walk controller: fetch, check, copy, write back, emit, advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= W_IDLE; head <= '0; cur <= '0;
            d_stat <= '0; d_buf <= '0; d_next <= '0; d_cnt <= '0; d_last <= 1'b0;
            widx <= '0; searching <= 1'b0; sent <= 1'b0; lenerr <= 1'b0; em_go <= 1'b0;
            flen <= '0; remain <= '0; baddr <= '0;
            mem_req_valid <= 1'b0; mem_req_write <= 1'b0;
            mem_req_addr <= '0; mem_req_wdata <= '0;
            busy <= 1'b0; tx_done <= 1'b0;
        end else begin
            if (hs) mem_req_valid <= 1'b0;
            em_go <= 1'b0;
            case (st)
                W_IDLE: if (start) begin
                    head <= head_ptr; cur <= head_ptr;
                    searching <= 1'b1; sent <= 1'b0; lenerr <= 1'b0; flen <= '0;
                    busy <= 1'b1; tx_done <= 1'b0;
                    if (head_ptr == '0) st <= W_DONE;
                    else begin
                        widx <= '0; mem_req_valid <= 1'b1; mem_req_write <= 1'b0;
                        mem_req_addr <= head_ptr; st <= W_DFETCH;
                    end
                end
                W_DFETCH: if (mem_rsp_valid) begin
                    case (widx)
                        2'd0: d_stat <= mem_rsp_data;
                        2'd1: begin d_cnt <= mem_rsp_data[CNT_W-1:0]; d_last <= mem_rsp_data[LAST_BIT]; end
                        2'd2: d_buf  <= mem_rsp_data;
                        default: d_next <= mem_rsp_data;
                    endcase
                    if (widx == 2'd3) st <= W_CHECK;
                    else begin
                        widx <= widx + 2'd1; mem_req_valid <= 1'b1;
                        mem_req_addr <= cur + {28'd0, widx + 2'd1, 2'b00};
                    end
                end
                W_CHECK: begin
                    if (!d_stat[OWN_BIT]) begin
                        if (searching && d_next != head && d_next != '0) begin
                            cur <= d_next; widx <= '0; mem_req_valid <= 1'b1;
                            mem_req_addr <= d_next; st <= W_DFETCH;
                        end else st <= W_DONE;
                    end else begin
                        searching <= 1'b0;
                        if (overflow) begin
                            lenerr <= 1'b1; mem_req_valid <= 1'b1; mem_req_write <= 1'b1;
                            mem_req_addr <= cur; mem_req_wdata <= d_stat | (32'd1 << LENERR_BIT);
                            st <= W_WBACK;
                        end else if (d_cnt == '0) begin
                            mem_req_valid <= 1'b1; mem_req_write <= 1'b1; mem_req_addr <= cur;
                            mem_req_wdata <= d_stat & ~(32'd1 << OWN_BIT); st <= W_WBACK;
                        end else begin
                            remain <= d_cnt; baddr <= d_buf; mem_req_valid <= 1'b1;
                            mem_req_addr <= d_buf; st <= W_BFETCH;
                        end
                    end
                end
                W_BFETCH: if (mem_rsp_valid) begin
                    flen   <= flen + LEN_W'(nb);
                    remain <= remain - CNT_W'(nb);
                    mem_req_valid <= 1'b1;
                    if (remain <= CNT_W'(4)) begin
                        mem_req_write <= 1'b1; mem_req_addr <= cur;
                        mem_req_wdata <= d_stat & ~(32'd1 << OWN_BIT); st <= W_WBACK;
                    end else begin
                        baddr <= baddr + 32'd4; mem_req_addr <= baddr + 32'd4;
                    end
                end
                W_WBACK: if (hs) begin
                    mem_req_write <= 1'b0;
                    if (lenerr)                       st <= W_DONE;
                    else if (d_last && flen != '0) begin em_go <= 1'b1; st <= W_EMIT; end
                    else                              st <= W_NEXT;
                end
                W_EMIT: if (frm_eof) begin
                    sent <= 1'b1; flen <= '0; st <= W_NEXT;
                end
                W_NEXT: begin
                    if (d_next == '0) st <= W_DONE;
                    else begin
                        cur <= d_next; widx <= '0; mem_req_valid <= 1'b1;
                        mem_req_addr <= d_next; st <= W_DFETCH;
                    end
                end
                default: begin
                    busy <= 1'b0; tx_done <= sent; st <= W_IDLE;
                end
            endcase
        end
    end

    txd_pktbuf #(.BYTES(BUF_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(st == W_BFETCH && mem_rsp_valid), .wr_base(flen),
        .wr_data(mem_rsp_data), .wr_nb(nb),
        .rd_idx(em_idx), .rd_data(frm_data)
    );

    txd_emit #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_emit (
        .clk(clk), .rst_n(rst_n), .go(em_go), .len(flen),
        .rd_idx(em_idx), .out_valid(frm_valid), .out_sof(frm_sof), .out_eof(frm_eof)
    );

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !frm_valid);
    p_fetch_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_DFETCH && mem_req_valid) |-> mem_req_addr == cur + {28'd0, widx, 2'b00});
    p_wback_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |->
            mem_req_addr == cur && mem_req_be == 4'hF &&
            (!mem_req_wdata[OWN_BIT] || mem_req_wdata[LENERR_BIT]));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flen <= LEN_W'(BUF_BYTES));
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> !busy);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_write));
endmodule

// File: tb/txd_gather_bench.sv
module txd_gather_bench;
    localparam int CLK_NS    = 10;
    localparam int MEM_WORDS = 4096;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] LAST = 32'h4000_0000;
    localparam logic [31:0] FRST = 32'h2000_0000;
    localparam logic [31:0] LERR = 32'h0000_4000;
    // {fragments, size0, size1, size2, expected frame length}
    localparam logic [46:0] VEC [0:5] = '{
        {2'd1, 11'd64,   11'd0,    11'd0, 12'd64},
        {2'd1, 11'd1,    11'd0,    11'd0, 12'd1},
        {2'd2, 11'd5,    11'd7,    11'd0, 12'd12},
        {2'd3, 11'd100,  11'd0,    11'd3, 12'd103},
        {2'd1, 11'd2047, 11'd0,    11'd0, 12'd2047},
        {2'd2, 11'd1024, 11'd1024, 11'd0, 12'd2048}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [31:0] head_ptr = '0;
    logic mem_req_valid, mem_req_write, mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0] mem_req_be;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic frm_valid, frm_sof, frm_eof, busy, tx_done;
    logic [7:0] frm_data;

    always #(CLK_NS/2) clk = ~clk;

    txd_gather u_txd_gather (.*);

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] rd_log [8];
    int rd_n = 0, cyc = 0, stall_bad = 0;
    logic prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [7:0] cap [4200];
    logic [7:0] expb [4200];
    int cap_n = 0, eof_n = 0, sof_bad = 0;
    logic in_frame = 1'b0;
    int checks = 0, errors = 0;

    // Memory model: one-cycle read latency, ready low every third cycle
    initial forever begin
        @(posedge clk);
        cyc++;
        if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr)) stall_bad++;
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) mem[mem_req_addr[13:2]] = mem_req_wdata;
            else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr[13:2]];
                if (rd_n < 8) rd_log[rd_n] = mem_req_addr;
                rd_n++;
            end
        end
        mem_req_ready <= (cyc % 3 != 1);
    end

    // Frame capture away from the clock edge
    initial forever begin
        @(negedge clk);
        if (frm_valid) begin
            if (frm_sof != !in_frame) sof_bad++;
            in_frame = !frm_eof;
            if (frm_eof) eof_n++;
            if (cap_n < 4200) cap[cap_n] = frm_data;
            cap_n++;
        end
    end

    initial begin
        #(CLK_NS * 195000);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return mem[a[13:2]][8*a[1:0] +: 8];
    endfunction

    task automatic set_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] c,
                            input logic [31:0] b, input logic [31:0] n);
        mem[a[13:2]] = s; mem[a[13:2]+1] = c; mem[a[13:2]+2] = b; mem[a[13:2]+3] = n;
    endtask

    task automatic pulse(input logic [31:0] hp);
        @(negedge clk); head_ptr = hp; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        int w = 0;
        while (busy && w < 30000) begin @(negedge clk); w++; end
        chk(w < 30000, "R9 walk ends", w, 30000);
    endtask

    task automatic run(input logic [31:0] hp);
        cap_n = 0; eof_n = 0; sof_bad = 0; rd_n = 0;
        pulse(hp);
        wait_idle();
    endtask

    function automatic int byte_mismatch(input int n);
        int bad = 0;
        for (int j = 0; j < n; j++) if (cap[j] != expb[j]) bad++;
        return bad;
    endfunction

    initial begin
        for (int w = 0; w < MEM_WORDS; w++) mem[w] = (w * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !tx_done, "R1 busy/done after reset", {busy, tx_done}, 0);
        chk(!mem_req_valid && !frm_valid, "R1 outputs quiet", {mem_req_valid, frm_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: single frame from 1..3 fragments, ring back to head
        for (int v = 0; v < 6; v++) begin
            int nf = int'(VEC[v][46:45]);
            int el = int'(VEC[v][11:0]);
            int e = 0;
            for (int f = 0; f < nf; f++) begin
                int sz = int'(VEC[v][45 - 11*(f+1) +: 11]);
                logic [31:0] da = 32'h100 + 32'(16*f);
                logic [31:0] ba = 32'h1000 + 32'(32'h800*f);
                set_desc(da, OWN | 32'h50 + 32'(f),
                         32'(sz) | ((f == nf-1) ? LAST : 32'h0) | ((f == 0) ? FRST : 32'h0),
                         ba, (f == nf-1) ? 32'h100 : da + 32'd16);
                for (int j = 0; j < sz; j++) begin expb[e] = mbyte(ba + 32'(j)); e++; end
            end
            run(32'h100);
            chk(eof_n == 1, "R6/R7 one frame per ring", eof_n, 1);
            chk(cap_n == el, "R4 frame length", cap_n, el);
            chk(byte_mismatch(el) == 0, "R4/R6 frame bytes", byte_mismatch(el), 0);
            chk(sof_bad == 0, "R6 sof marker", sof_bad, 0);
            chk(tx_done, "R9 done after frame", tx_done, 1);
            for (int f = 0; f < nf; f++)
                chk(mem[(32'h100 + 16*f) >> 2] == 32'h50 + 32'(f), "R5 ownership returned",
                    mem[(32'h100 + 16*f) >> 2], 32'h50 + 32'(f));
        end

        // R3: skip two unowned descriptors from the head
        set_desc(32'h500, 32'h11, LAST | 32'd9, 32'h1000, 32'h510);
        set_desc(32'h510, 32'h12, LAST | 32'd9, 32'h1000, 32'h520);
        set_desc(32'h520, OWN | 32'h13, LAST | 32'd10, 32'h1800, 32'h500);
        for (int j = 0; j < 10; j++) expb[j] = mbyte(32'h1800 + 32'(j));
        run(32'h500);
        chk(eof_n == 1 && cap_n == 10, "R3 skip to owned", cap_n, 10);
        chk(byte_mismatch(10) == 0, "R3 skipped frame bytes", byte_mismatch(10), 0);
        chk(mem[32'h500 >> 2] == 32'h11, "R3 unowned untouched", mem[32'h500 >> 2], 32'h11);

        // R7: two frames in one walk, stop at unowned third
        set_desc(32'h700, OWN | FRST, LAST | FRST | 32'd8, 32'h1000, 32'h710);
        set_desc(32'h710, OWN | FRST, LAST | FRST | 32'd20, 32'h1800, 32'h720);
        set_desc(32'h720, 32'h77, LAST | 32'd5, 32'h2000, 32'h700);
        run(32'h700);
        chk(eof_n == 2 && cap_n == 28, "R7 two frames", {eof_n[15:0], cap_n[15:0]}, {16'd2, 16'd28});
        chk(mem[32'h720 >> 2] == 32'h77, "R7 stop at unowned", mem[32'h720 >> 2], 32'h77);
        chk(tx_done, "R9 done set", tx_done, 1);

        // R3/R9: ring with nothing owned gives up, clears done
        set_desc(32'h600, 32'h0, LAST | 32'd4, 32'h1000, 32'h610);
        set_desc(32'h610, 32'h0, LAST | 32'd4, 32'h1000, 32'h600);
        run(32'h600);
        chk(eof_n == 0 && !busy, "R3 give up on wrap", eof_n, 0);
        chk(!tx_done, "R9 done cleared by start", tx_done, 0);
        set_desc(32'h620, 32'h0, LAST | 32'd4, 32'h1000, 32'h0);
        run(32'h620);
        chk(eof_n == 0 && !busy, "R3 give up on null next", eof_n, 0);

        // R2/R7: fetch order, null next ends walk
        set_desc(32'h140, OWN, LAST | 32'd4, 32'h2000, 32'h0);
        run(32'h140);
        chk(rd_log[0] == 32'h140 && rd_log[1] == 32'h144, "R2 fetch order a", rd_log[1], 32'h144);
        chk(rd_log[2] == 32'h148 && rd_log[3] == 32'h14C, "R2 fetch order b", rd_log[3], 32'h14C);
        chk(rd_log[4] == 32'h2000, "R4 buffer read address", rd_log[4], 32'h2000);
        chk(eof_n == 1 && tx_done, "R7 null next after frame", eof_n, 1);

        // R8: overflow on second fragment
        set_desc(32'h200, OWN | 32'h3, FRST | 32'd1500, 32'h1000, 32'h210);
        set_desc(32'h210, OWN | 32'h5, LAST | 32'd1000, 32'h1800, 32'h200);
        run(32'h200);
        chk(mem[32'h200 >> 2] == 32'h3, "R8 first fragment returned", mem[32'h200 >> 2], 32'h3);
        chk(mem[32'h210 >> 2] == (OWN | LERR | 32'h5), "R8 length error status",
            mem[32'h210 >> 2], OWN | LERR | 32'h5);
        chk(eof_n == 0 && !tx_done, "R8 no frame on overflow", eof_n, 0);

        // R10: second start during a walk is ignored
        set_desc(32'h300, OWN, LAST | 32'd200, 32'h1000, 32'h0);
        set_desc(32'h380, OWN | 32'h9, LAST | 32'd16, 32'h1800, 32'h0);
        cap_n = 0; eof_n = 0; sof_bad = 0;
        pulse(32'h300);
        repeat (3) @(negedge clk);
        pulse(32'h380);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(!busy && eof_n == 1 && cap_n == 200, "R10 start while busy ignored", cap_n, 200);
        chk(mem[32'h380 >> 2] == (OWN | 32'h9), "R10 other ring untouched", mem[32'h380 >> 2], OWN | 32'h9);

        chk(stall_bad == 0, "R11 request held under stall", stall_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule